// File: doc/BRIEF.md
# Per-Frame Payload Octet Counter

This block runs beside one direction of an Ethernet MAC datapath and measures the payload of every frame that passes. Each clock cycle is one beat. A beat carries between zero and eight valid bytes and may be marked as the first or last beat of a frame. At the last beat the block also samples four error indications. A frame's payload is its total byte count less the 14-byte MAC header and the 4-byte FCS, with zero as the lower limit.

For each frame that is free of errors, the block presents the 16-bit payload count on an output register. It raises a strobe for one cycle, in the cycle after the last beat. While the strobe is low, the count output carries no meaning. A 64-bit running total adds the payload of each error-free frame. This total is updated only while statistics collection is enabled, and a synchronous clear input sets it to zero. The per-frame count and strobe keep working when statistics collection is disabled.

One instance is placed in the transmit MAC clock domain and another in the receive MAC clock domain. The two instances are independent.

Top module: `frame_payload_counter`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `frame_octets_vld` is 0, `frame_octets` is 0 and `total_octets` is 0.
- R2: When a frame's last beat (`eof`=1) ends a frame that was opened by `sof`, `frame_octets_vld` is 1 in the next cycle only, and `frame_octets` equals the frame's byte total minus 18. A frame may open and close in the same beat.
- R3: A qualifying frame with a byte total of 18 or less reports `frame_octets` = 0, and its strobe still fires.
- R4: A payload greater than 65535 is reported as 65535.
- R5: If any of `err_fcs`, `err_oversize`, `err_undersize` or `err_length` is 1 in the `eof` beat, no strobe is issued and `total_octets` does not change.
- R6: With `stats_en`=1 in the `eof` beat, each qualifying frame adds its reported payload to `total_octets`. The new total is visible in the same cycle as the strobe.
- R7: With `stats_en`=0 in the `eof` beat, the strobe and the count behave as in R2, and `total_octets` does not change.
- R8: A `sof` that arrives while a frame is still open discards the partial frame. No strobe is issued for the discarded frame, and the new frame is counted from its own `sof` beat.
- R9: Beats with `beat_bytes`=0 inside a frame do not change the frame's byte total.
- R10: `total_clr`=1 sets `total_octets` to 0 in the next cycle. This takes priority over an addition in the same cycle.
- R11: An `eof` beat when no frame is open produces no strobe and leaves `total_octets` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | MAC clock of this direction |
| rst_n | input | 1 | Synchronous reset, active low |
| sof | input | 1 | Beat is the first of a frame |
| eof | input | 1 | Beat is the last of a frame |
| beat_bytes | input | 4 | Valid bytes in this beat, 0 to 8 |
| err_fcs | input | 1 | FCS error, sampled with eof |
| err_oversize | input | 1 | Oversize error, sampled with eof |
| err_undersize | input | 1 | Undersize error, sampled with eof |
| err_length | input | 1 | Payload length error, sampled with eof |
| stats_en | input | 1 | Enables updates of the running total |
| total_clr | input | 1 | Synchronous clear of the running total |
| frame_octets | output | 16 | Payload bytes of the last qualifying frame |
| frame_octets_vld | output | 1 | One-cycle strobe marking frame_octets valid |
| total_octets | output | 64 | Running payload total of qualifying frames |

## Verification
The hardest case to reach is the saturation of the 16-bit count. It needs a single frame of more than 65553 bytes. The stimulus reaches it by streaming thousands of full eight-byte beats: one frame lands exactly on 65535 and another goes well past it. A second hard case is a frame that is abandoned part-way. The bench opens a frame, sends several beats and then starts a new frame without closing the first. It then checks that no strobe appears, that the total is unchanged and that only the new frame's bytes are counted.

// File: rtl/payload_octet_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the per-frame payload octet counter.
package payload_octet_pkg;
    localparam int unsigned HDR_BYTES      = 14;
    localparam int unsigned FCS_BYTES      = 4;
    localparam int unsigned OVERHEAD_BYTES = HDR_BYTES + FCS_BYTES;

    // Error indications sampled in the end-of-frame beat.
    typedef struct packed {
        logic fcs;
        logic oversize;
        logic undersize;
        logic length;
    } frame_err_t;
endpackage

// File: rtl/frame_byte_accum.sv
`timescale 1ns/1ps
// Accumulates the byte total of the frame that is open.
// Assumes beat_bytes never exceeds the beat width. The total saturates at
// its maximum. A start beat restarts the count and drops any open frame.
// frame_done and frame_bytes are combinational for the closing beat.
module frame_byte_accum #(
    parameter int BEAT_W = 4,
    parameter int ACC_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              eof,
    input  logic [BEAT_W-1:0] beat_bytes,
    output logic              frame_done,
    output logic [ACC_W-1:0]  frame_bytes
);
    logic             in_frame;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] base;
    logic [ACC_W:0]   sum_ext;

    // Running total including the present beat, saturated at its maximum.
    always_comb begin
        base    = sof ? '0 : acc;
        sum_ext = {1'b0, base} + (ACC_W+1)'(beat_bytes);
        frame_bytes = sum_ext[ACC_W] ? {ACC_W{1'b1}} : sum_ext[ACC_W-1:0];
        frame_done  = eof && (sof || in_frame);
    end

    // Frame-open flag and accumulator update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
            acc      <= '0;
        end else if (eof) begin
            in_frame <= 1'b0;
            acc      <= '0;
        end else if (sof) begin
            in_frame <= 1'b1;
            acc      <= frame_bytes;
        end else if (in_frame) begin
            acc      <= frame_bytes;
        end
    end
endmodule

// File: rtl/frame_qualify.sv
`timescale 1ns/1ps
// Turns a finished frame's byte total into a payload count. The header and
// FCS bytes are removed, with zero as the floor and the count's maximum as
// the ceiling. The frame is qualified on its error flags, and the count and
// strobe are registered. The add request for the running total is
// combinational, so the total moves on the same edge as the strobe.
module frame_qualify
    import payload_octet_pkg::*;
#(
    parameter int ACC_W = 17,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_done,
    input  logic [ACC_W-1:0] frame_bytes,
    input  frame_err_t       errs,
    input  logic             stats_en,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_vld,
    output logic             add_en,
    output logic [CNT_W-1:0] add_amt
);
    localparam logic [ACC_W-1:0] OVH     = ACC_W'(OVERHEAD_BYTES);
    localparam logic [ACC_W-1:0] CNT_MAX = ACC_W'({CNT_W{1'b1}});

    logic [ACC_W-1:0] diff;
    logic [CNT_W-1:0] payload;
    logic             qual;

    // Payload after overhead removal, clamped at both ends.
    always_comb begin
        diff = frame_bytes - OVH;
        if (frame_bytes <= OVH)
            payload = '0;
        else if (diff > CNT_MAX)
            payload = {CNT_W{1'b1}};
        else
            payload = diff[CNT_W-1:0];
        qual    = frame_done && (errs == '0);
        add_en  = qual && stats_en;
        add_amt = payload;
    end

    // Registered per-frame report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            cnt_vld <= 1'b0;
        end else begin
            cnt_vld <= qual;
            if (qual)
                cnt <= payload;
        end
    end
endmodule

// File: rtl/octet_total.sv
`timescale 1ns/1ps
// Running total of qualifying payload bytes. It wraps on overflow, and a
// clear takes priority over an addition in the same cycle.
module octet_total #(
    parameter int CNT_W = 16,
    parameter int TOT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             add_en,
    input  logic [CNT_W-1:0] add_amt,
    output logic [TOT_W-1:0] total
);
    // Clear, add or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            total <= '0;
        else if (add_en)
            total <= total + TOT_W'(add_amt);
    end
endmodule

// File: rtl/frame_payload_counter.sv
`timescale 1ns/1ps
// Per-frame payload octet counter for one MAC direction and clock domain.
// One beat per cycle carries 0 to MAX_BEAT_BYTES bytes. Error flags are
// valid with eof. The count and strobe appear one cycle after eof.
module frame_payload_counter
    import payload_octet_pkg::*;
#(
    parameter int MAX_BEAT_BYTES = 8,
    parameter int CNT_W          = 16,
    parameter int TOT_W          = 64,
    localparam int BEAT_W        = $clog2(MAX_BEAT_BYTES + 1),
    localparam int ACC_W         = CNT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sof,
    input  logic              eof,
    input  logic [BEAT_W-1:0] beat_bytes,
    input  logic              err_fcs,
    input  logic              err_oversize,
    input  logic              err_undersize,
    input  logic              err_length,
    input  logic              stats_en,
    input  logic              total_clr,
    output logic [CNT_W-1:0]  frame_octets,
    output logic              frame_octets_vld,
    output logic [TOT_W-1:0]  total_octets
);
    frame_err_t       errs;
    logic             frame_done;
    logic [ACC_W-1:0] frame_bytes;
    logic             add_en;
    logic [CNT_W-1:0] add_amt;

    // Gather the error flags into one word.
    always_comb begin
        errs = '{fcs: err_fcs, oversize: err_oversize,
                 undersize: err_undersize, length: err_length};
    end

    frame_byte_accum #(.BEAT_W(BEAT_W), .ACC_W(ACC_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .sof(sof), .eof(eof),
        .beat_bytes(beat_bytes), .frame_done(frame_done),
        .frame_bytes(frame_bytes)
    );

    frame_qualify #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_qual (
        .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
        .frame_bytes(frame_bytes), .errs(errs), .stats_en(stats_en),
        .cnt(frame_octets), .cnt_vld(frame_octets_vld),
        .add_en(add_en), .add_amt(add_amt)
    );

    octet_total #(.CNT_W(CNT_W), .TOT_W(TOT_W)) u_total (
        .clk(clk), .rst_n(rst_n), .clr(total_clr), .add_en(add_en),
        .add_amt(add_amt), .total(total_octets)
    );
endmodule

// File: rtl/frame_payload_counter_chk.sv
`timescale 1ns/1ps
// Port-level properties of the payload octet counter, bound into the top.
module frame_payload_counter_chk #(
    parameter int CNT_W = 16,
    parameter int TOT_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eof,
    input logic             err_fcs,
    input logic             err_oversize,
    input logic             err_undersize,
    input logic             err_length,
    input logic             stats_en,
    input logic             total_clr,
    input logic [CNT_W-1:0] frame_octets,
    input logic             frame_octets_vld,
    input logic [TOT_W-1:0] total_octets
);
    a_r2_strobe_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
        frame_octets_vld |-> $past(eof));

    a_r5_error_blocks_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (eof && (err_fcs || err_oversize || err_undersize || err_length))
        |=> !frame_octets_vld);

    a_r6_total_adds_count: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_octets_vld && $past(stats_en) && !$past(total_clr))
        |-> total_octets == $past(total_octets) + TOT_W'(frame_octets));

    a_r5_total_holds_without_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_octets_vld && !$past(total_clr)) |-> $stable(total_octets));

    a_r7_disabled_total_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!stats_en && !total_clr) |=> $stable(total_octets));

    a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        total_clr |=> total_octets == '0);
endmodule

bind frame_payload_counter frame_payload_counter_chk #(.CNT_W(CNT_W), .TOT_W(TOT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .eof(eof), .err_fcs(err_fcs),
    .err_oversize(err_oversize), .err_undersize(err_undersize),
    .err_length(err_length), .stats_en(stats_en), .total_clr(total_clr),
    .frame_octets(frame_octets), .frame_octets_vld(frame_octets_vld),
    .total_octets(total_octets)
);

// File: tb/frame_payload_counter_tb.sv
`timescale 1ns/1ps
module frame_payload_counter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof = 1'b0, eof = 1'b0;
    logic [3:0]  beat_bytes = '0;
    logic        err_fcs = 1'b0, err_oversize = 1'b0;
    logic        err_undersize = 1'b0, err_length = 1'b0;
    logic        stats_en = 1'b1, total_clr = 1'b0;
    logic [15:0] frame_octets;
    logic        frame_octets_vld;
    logic [63:0] total_octets;

    int          checks = 0;
    int          errors = 0;
    logic [63:0] model_total = '0;

    always #2.5 clk = ~clk;

    frame_payload_counter u_dut (
        .clk(clk), .rst_n(rst_n), .sof(sof), .eof(eof),
        .beat_bytes(beat_bytes), .err_fcs(err_fcs),
        .err_oversize(err_oversize), .err_undersize(err_undersize),
        .err_length(err_length), .stats_en(stats_en), .total_clr(total_clr),
        .frame_octets(frame_octets), .frame_octets_vld(frame_octets_vld),
        .total_octets(total_octets)
    );

    // Vectors: frame bytes, error flags {fcs,oversize,undersize,length}, idle gaps, tag.
    localparam int NV = 10;
    localparam int          V_BYTES [NV] = '{64, 18, 10, 19, 100, 1500, 61, 5, 300, 333};
    localparam logic [3:0]  V_ERR   [NV] = '{4'h0, 4'h0, 4'h0, 4'h0, 4'h8, 4'h0, 4'h1, 4'h0, 4'h4, 4'h0};
    localparam logic        V_GAP   [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sof = 0; eof = 0; beat_bytes = 0;
        {err_fcs, err_oversize, err_undersize, err_length} = 4'h0;
        total_clr = 0;
    endtask

    // Send one frame, then check the strobe, count and total, and that the strobe is one cycle long.
    task automatic send_frame(input int n, input logic [3:0] e, input logic gap,
                              input logic sen, input logic clr, input string req);
        int beats = (n + 7) / 8;
        int left  = n;
        int pay;
        logic qual;
        if (beats == 0) beats = 1;
        for (int b = 0; b < beats; b++) begin
            @(negedge clk);
            idle_inputs();
            stats_en   = sen;
            sof        = (b == 0);
            eof        = (b == beats - 1);
            beat_bytes = 4'((left > 8) ? 8 : left);
            left       = left - ((left > 8) ? 8 : left);
            if (b == beats - 1) begin
                {err_fcs, err_oversize, err_undersize, err_length} = e;
                total_clr = clr;
            end
            if (gap && b != beats - 1) begin
                @(negedge clk);
                idle_inputs();
            end
        end
        @(negedge clk);
        idle_inputs();
        stats_en = 1;
        pay  = (n <= 18) ? 0 : ((n - 18 > 65535) ? 65535 : n - 18);
        qual = (e == 4'h0);
        if (clr) model_total = '0;
        else if (qual && sen) model_total = model_total + 64'(pay);
        chk(frame_octets_vld == qual, {req, " strobe"}, 64'(frame_octets_vld), 64'(qual));
        if (qual) chk(frame_octets == 16'(pay), {req, " count"}, 64'(frame_octets), 64'(pay));
        chk(total_octets == model_total, {req, " total"}, total_octets, model_total);
        @(negedge clk);
        chk(frame_octets_vld == 1'b0, "R2 single-cycle strobe", 64'(frame_octets_vld), 0);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(frame_octets_vld == 0, "R1 strobe in reset", 64'(frame_octets_vld), 0);
        chk(total_octets == 0, "R1 total in reset", total_octets, 0);
        rst_n = 1;
        @(negedge clk);
        chk(frame_octets_vld == 0, "R1 strobe after reset", 64'(frame_octets_vld), 0);
        chk(frame_octets == 0, "R1 count after reset", 64'(frame_octets), 0);
        chk(total_octets == 0, "R1 total after reset", total_octets, 0);

        // Table walk: R2, R3, R5, R6, R9 (gap vectors).
        for (int i = 0; i < NV; i++)
            send_frame(V_BYTES[i], V_ERR[i], V_GAP[i], 1'b1, 1'b0,
                       V_GAP[i] ? "R9" : (V_ERR[i] != 0 ? "R5" : (V_BYTES[i] <= 18 ? "R3" : "R2 R6")));

        // R7: statistics disabled, count still reported.
        send_frame(90, 4'h0, 1'b0, 1'b0, 1'b0, "R7");

        // R8: abandoned partial frame.
        @(negedge clk); idle_inputs(); sof = 1; beat_bytes = 8;
        @(negedge clk); idle_inputs(); beat_bytes = 8;
        @(negedge clk); idle_inputs(); beat_bytes = 8;
        @(negedge clk); idle_inputs();
        chk(frame_octets_vld == 0, "R8 no strobe for partial", 64'(frame_octets_vld), 0);
        send_frame(30, 4'h0, 1'b0, 1'b1, 1'b0, "R8");

        // R11: eof with no open frame.
        @(negedge clk); idle_inputs(); eof = 1; beat_bytes = 8;
        @(negedge clk); idle_inputs();
        chk(frame_octets_vld == 0, "R11 stray eof strobe", 64'(frame_octets_vld), 0);
        chk(total_octets == model_total, "R11 stray eof total", total_octets, model_total);

        // R4: saturation of the per-frame count.
        send_frame(65553, 4'h0, 1'b0, 1'b1, 1'b0, "R4");
        send_frame(70000, 4'h0, 1'b0, 1'b1, 1'b0, "R4");

        // R10: plain clear, then clear together with an addition.
        @(negedge clk); idle_inputs(); total_clr = 1;
        @(negedge clk); idle_inputs();
        model_total = '0;
        chk(total_octets == 0, "R10 clear", total_octets, 0);
        send_frame(40, 4'h0, 1'b0, 1'b1, 1'b0, "R10 refill");
        send_frame(50, 4'h0, 1'b0, 1'b1, 1'b1, "R10");

        finish_run();
    end
endmodule